// File: doc/BRIEF.md
# Reset Sequencer with Strap Latch

This block turns four reset requests into the reset lines of four domains: emulation logic, isolated peripherals, the rest of the system, and the processor core. The requests are ranked by reach. Power-on is the widest, then full warm reset, then system reset, then core-local reset. When two requests arrive in the same cycle, the wider one wins. The reset lines stay asserted while a request is held. After the request drops they stay asserted for a programmable stretch, and then they release together on a clock edge.

A power-on or full warm reset also captures the 13 bootstrap pins into a status word. This happens on the release edge, after the pins have passed through a two-stage synchronizer. The status word is split into three fields:
- a boot device select;
- a device-specific configuration field;
- a top field that is either a PLL multiplier select or, for the two serial-memory boot devices, extra configuration with the PLL held in bypass.

When a reset releases, the block sends one of two one-cycle pulses:
- a boot-start pulse to the boot engine; or
- when the power-state hibernation flag is set after a wide reset, a resume pulse together with the stored resume address.

Top module: `rst_seq_top`

## Requirements
- R1: A core-local request asserts only `core_rst`. A system request asserts `sys_rst` and `core_rst`. A full warm or power-on request asserts all four of `emu_rst`, `iso_rst`, `sys_rst` and `core_rst`.
- R2: When several requests are sampled together, the domain set of the widest one applies. A narrower request that arrives while a wider reset is still in progress does not shrink the asserted set.
- R3: With `hold_cycles` = N, the reset outputs deassert at the (N+1)-th consecutive rising edge that samples no request. A new request reloads the stretch.
- R4: A power-on or full warm reset loads the synchronized strap value into `strap_word` at the release edge. While `por_req` is held, `strap_word` reads zero.
- R5: A system or core-local reset leaves `strap_word` unchanged.
- R6: After a system reset, or after a power-on/full reset with `hib_flag` low, `boot_start` is high for exactly one cycle. That cycle is the first one in which `core_rst` is low.
- R7: A core-local reset produces neither `boot_start` nor `resume_go`.
- R8: After a power-on/full reset with `hib_flag` high, `resume_go` pulses for one cycle in place of `boot_start`, and `resume_pc` equals `resume_addr` as sampled at release. A system reset ignores `hib_flag`.
- R9: `boot_dev` = `strap_word[2:0]` and `boot_cfg` = `strap_word[9:3]`. Bits [12:10] feed the top field.
- R10: When `boot_dev` is 3'b001 (I2C) or 3'b010 (SPI), `pll_bypass` = 1, `pll_mult` = 0 and `ext_cfg` = `strap_word[12:10]`. Otherwise `pll_bypass` = 0, `pll_mult` = `strap_word[12:10]` and `ext_cfg` = 0.
- R11: Straps pass through two flops before capture. A pin change made after the rising edge two cycles before the release edge is not captured by that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on reset request (widest) |
| full_req | input | 1 | Full warm reset request |
| sys_req | input | 1 | System reset request |
| core_req | input | 1 | Core-local reset request (narrowest) |
| hold_cycles | input | 16 | Stretch length N after the request drops |
| strap_pins | input | 13 | Bootstrap pins, asynchronous |
| hib_flag | input | 1 | Hibernation flag from the power-state register |
| resume_addr | input | 32 | Resume address from the power-state register |
| emu_rst | output | 1 | Emulation domain reset |
| iso_rst | output | 1 | Isolated-peripheral domain reset |
| sys_rst | output | 1 | System domain reset |
| core_rst | output | 1 | Processor core reset |
| boot_start | output | 1 | One-cycle boot start pulse |
| resume_go | output | 1 | One-cycle hibernation resume pulse |
| resume_pc | output | 32 | Latched resume address |
| strap_word | output | 13 | Latched strap status word |
| boot_dev | output | 3 | Boot device select field |
| boot_cfg | output | 7 | Device-specific configuration field |
| pll_mult | output | 3 | PLL multiplier select (0 in bypass) |
| ext_cfg | output | 3 | Extended configuration (bypass devices only) |
| pll_bypass | output | 1 | PLL held in bypass |

## Verification
The following faults each show at the ports within one reset episode:
- A wrong held reset class shows up at once as the wrong set of domain lines asserted during the stretch.
- A wrong stretch counter shows up as a release edge that comes early or late against N+1.
- A wrong release decision shows up in the first cycle after `core_rst` falls, as a missing, doubled or misrouted boot or resume pulse.
- A strap capture taken at the wrong time or by the wrong class shows up as a changed or stale `strap_word` immediately after that release.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [2:0] {
    CLS_NONE = 3'd0,
    CLS_CORE = 3'd1,
    CLS_SYS  = 3'd2,
    CLS_FULL = 3'd3,
    CLS_POR  = 3'd4
  } rst_cls_e;

  typedef struct packed {
    logic emu;
    logic iso;
    logic sys;
    logic core;
  } dom_t;

  localparam logic [2:0] DEV_I2C = 3'b001;
  localparam logic [2:0] DEV_SPI = 3'b010;

  // Widest request wins.
  function automatic rst_cls_e cls_pick(input logic por, input logic full,
                                        input logic sys, input logic core);
    if (por)       return CLS_POR;
    else if (full) return CLS_FULL;
    else if (sys)  return CLS_SYS;
    else if (core) return CLS_CORE;
    else           return CLS_NONE;
  endfunction

  function automatic rst_cls_e cls_wider(input rst_cls_e a, input rst_cls_e b);
    return (a > b) ? a : b;
  endfunction

  function automatic dom_t dom_of(input rst_cls_e c);
    dom_t d;
    d.core = (c >= CLS_CORE);
    d.sys  = (c >= CLS_SYS);
    d.iso  = (c >= CLS_FULL);
    d.emu  = (c >= CLS_FULL);
    return d;
  endfunction

  // Classes that re-sample the straps and consult hibernation.
  function automatic logic cls_latches(input rst_cls_e c);
    return c >= CLS_FULL;
  endfunction

  // Classes that end in a boot (or resume) decision.
  function automatic logic cls_boots(input rst_cls_e c);
    return c >= CLS_SYS;
  endfunction

  function automatic logic dev_bypass(input logic [2:0] dev);
    return (dev == DEV_I2C) || (dev == DEV_SPI);
  endfunction

endpackage

// File: rtl/rs_prio.sv
module rs_prio
  import rs_pkg::*;
(
  input  logic     por_req,
  input  logic     full_req,
  input  logic     sys_req,
  input  logic     core_req,
  output rst_cls_e in_cls,
  output logic     req_any
);
  always_comb begin
    in_cls  = cls_pick(por_req, full_req, sys_req, core_req);
    req_any = (in_cls != CLS_NONE);
  end
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             por_req,
  input  rst_cls_e         in_cls,
  input  logic             req_any,
  input  logic [CNT_W-1:0] hold_cycles,
  output dom_t             dom,
  output logic             rel_evt,
  output rst_cls_e         rel_cls
);
  logic             busy_q;
  rst_cls_e         cls_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (por_req) begin
      busy_q <= 1'b1;
      cls_q  <= CLS_POR;
      cnt_q  <= hold_cycles;
    end else if (req_any) begin
      busy_q <= 1'b1;
      cnt_q  <= hold_cycles;
      cls_q  <= busy_q ? cls_wider(cls_q, in_cls) : in_cls;
    end else if (busy_q) begin
      if (cnt_zero) busy_q <= 1'b0;
      else          cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    dom     = busy_q ? dom_of(cls_q) : '0;
    rel_evt = busy_q && !req_any && cnt_zero;
    rel_cls = cls_q;
  end
endmodule

// File: rtl/rs_boot.sv
module rs_boot
  import rs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              rel_evt,
  input  rst_cls_e          rel_cls,
  input  logic              hib_flag,
  input  logic [ADDR_W-1:0] resume_addr,
  output logic              boot_start,
  output logic              resume_go,
  output logic [ADDR_W-1:0] resume_pc
);
  logic wide, take_resume, take_boot;

  always_comb begin
    wide        = cls_latches(rel_cls);
    take_resume = rel_evt && wide && hib_flag;
    take_boot   = rel_evt && cls_boots(rel_cls) && !(wide && hib_flag);
  end

  always_ff @(posedge clk) begin
    if (por_req) begin
      boot_start <= 1'b0;
      resume_go  <= 1'b0;
      resume_pc  <= '0;
    end else begin
      boot_start <= take_boot;
      resume_go  <= take_resume;
      if (take_resume) resume_pc <= resume_addr;
    end
  end
endmodule

// File: rtl/rs_strap.sv
module rs_strap
  import rs_pkg::*;
#(
  parameter int STRAP_W = 13,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               por_req,
  input  logic [STRAP_W-1:0] strap_pins,
  input  logic               cap_evt,
  output logic [STRAP_W-1:0] strap_word,
  output logic [2:0]         boot_dev,
  output logic [6:0]         boot_cfg,
  output logic [STRAP_W-11:0] pll_mult,
  output logic [STRAP_W-11:0] ext_cfg,
  output logic               pll_bypass
);
  localparam int DEV_LO = 0;
  localparam int CFG_LO = 3;
  localparam int TOP_LO = 10;
  localparam int TOP_W  = STRAP_W - TOP_LO;

  logic [STRAP_W-1:0] sync_q [SYNC_N];

  genvar g;
  generate
    for (g = 0; g < SYNC_N; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) sync_q[g] <= strap_pins;
      end else begin : g_next
        always_ff @(posedge clk) sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (por_req)      strap_word <= '0;
    else if (cap_evt) strap_word <= sync_q[SYNC_N-1];
  end

  logic [TOP_W-1:0] top_f;
  always_comb begin
    boot_dev   = strap_word[DEV_LO +: 3];
    boot_cfg   = strap_word[CFG_LO +: 7];
    top_f      = strap_word[TOP_LO +: TOP_W];
    pll_bypass = dev_bypass(boot_dev);
    pll_mult   = pll_bypass ? '0 : top_f;
    ext_cfg    = pll_bypass ? top_f : '0;
  end
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rs_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int STRAP_W = 13,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               por_req,
  input  logic               full_req,
  input  logic               sys_req,
  input  logic               core_req,
  input  logic [CNT_W-1:0]   hold_cycles,
  input  logic [STRAP_W-1:0] strap_pins,
  input  logic               hib_flag,
  input  logic [ADDR_W-1:0]  resume_addr,
  output logic               emu_rst,
  output logic               iso_rst,
  output logic               sys_rst,
  output logic               core_rst,
  output logic               boot_start,
  output logic               resume_go,
  output logic [ADDR_W-1:0]  resume_pc,
  output logic [STRAP_W-1:0] strap_word,
  output logic [2:0]         boot_dev,
  output logic [6:0]         boot_cfg,
  output logic [STRAP_W-11:0] pll_mult,
  output logic [STRAP_W-11:0] ext_cfg,
  output logic               pll_bypass
);
  rst_cls_e in_cls, rel_cls;
  logic     req_any, rel_evt, cap_evt;
  dom_t     dom;

  rs_prio u_prio (
    .por_req(por_req), .full_req(full_req), .sys_req(sys_req),
    .core_req(core_req), .in_cls(in_cls), .req_any(req_any)
  );

  rs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .por_req(por_req), .in_cls(in_cls), .req_any(req_any),
    .hold_cycles(hold_cycles), .dom(dom), .rel_evt(rel_evt), .rel_cls(rel_cls)
  );

  assign cap_evt = rel_evt && cls_latches(rel_cls);

  rs_strap #(.STRAP_W(STRAP_W)) u_strap (
    .clk(clk), .por_req(por_req), .strap_pins(strap_pins), .cap_evt(cap_evt),
    .strap_word(strap_word), .boot_dev(boot_dev), .boot_cfg(boot_cfg),
    .pll_mult(pll_mult), .ext_cfg(ext_cfg), .pll_bypass(pll_bypass)
  );

  rs_boot #(.ADDR_W(ADDR_W)) u_boot (
    .clk(clk), .por_req(por_req), .rel_evt(rel_evt), .rel_cls(rel_cls),
    .hib_flag(hib_flag), .resume_addr(resume_addr),
    .boot_start(boot_start), .resume_go(resume_go), .resume_pc(resume_pc)
  );

  assign emu_rst  = dom.emu;
  assign iso_rst  = dom.iso;
  assign sys_rst  = dom.sys;
  assign core_rst = dom.core;
endmodule

// File: rtl/rs_chk.sv
module rs_chk #(
  parameter int STRAP_W = 13
) (
  input logic               clk,
  input logic               por_req,
  input logic               full_req,
  input logic               sys_req,
  input logic               core_req,
  input logic               emu_rst,
  input logic               iso_rst,
  input logic               sys_rst,
  input logic               core_rst,
  input logic               boot_start,
  input logic               resume_go,
  input logic [STRAP_W-1:0] strap_word,
  input logic [2:0]         boot_dev,
  input logic               pll_bypass,
  input logic               rel_evt
);
  // R1
  sys_nest_chk: assert property (@(posedge clk) disable iff (por_req)
    sys_rst |-> core_rst);
  // R1
  emu_nest_chk: assert property (@(posedge clk) disable iff (por_req)
    emu_rst |-> (sys_rst && iso_rst));
  // R2
  req_take_chk: assert property (@(posedge clk) disable iff (por_req)
    (full_req || sys_req || core_req) |=> core_rst);
  // R3
  quiet_fall_chk: assert property (@(posedge clk) disable iff (por_req)
    $fell(core_rst) |-> $past(!full_req && !sys_req && !core_req));
  // R3
  rel_fall_chk: assert property (@(posedge clk) disable iff (por_req)
    rel_evt |=> !core_rst);
  // R5
  strap_hold_chk: assert property (@(posedge clk) disable iff (por_req)
    !$past(emu_rst) |-> $stable(strap_word));
  // R6
  boot_pulse_chk: assert property (@(posedge clk) disable iff (por_req)
    boot_start |=> !boot_start);
  // R6
  boot_edge_chk: assert property (@(posedge clk) disable iff (por_req)
    boot_start |-> $fell(core_rst));
  // R7
  core_noboot_chk: assert property (@(posedge clk) disable iff (por_req)
    (core_rst && !sys_rst) |=> (!boot_start && !resume_go));
  // R8
  resume_excl_chk: assert property (@(posedge clk) disable iff (por_req)
    resume_go |-> (!boot_start && $fell(emu_rst)));
  // R10
  bypass_dev_chk: assert property (@(posedge clk) disable iff (por_req)
    pll_bypass |-> (boot_dev == 3'b001 || boot_dev == 3'b010));
endmodule

bind rst_seq_top rs_chk #(.STRAP_W(STRAP_W)) u_rs_chk (
  .clk(clk), .por_req(por_req), .full_req(full_req), .sys_req(sys_req),
  .core_req(core_req), .emu_rst(emu_rst), .iso_rst(iso_rst), .sys_rst(sys_rst),
  .core_rst(core_rst), .boot_start(boot_start), .resume_go(resume_go),
  .strap_word(strap_word), .boot_dev(boot_dev), .pll_bypass(pll_bypass),
  .rel_evt(rel_evt)
);

// File: tb/tb_rst_seq_top.sv
module tb_rst_seq_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        por_req, full_req, sys_req, core_req;
  logic [15:0] hold_cycles;
  logic [12:0] strap_pins;
  logic        hib_flag;
  logic [31:0] resume_addr;
  logic        emu_rst, iso_rst, sys_rst, core_rst, boot_start, resume_go;
  logic [31:0] resume_pc;
  logic [12:0] strap_word;
  logic [2:0]  boot_dev, pll_mult, ext_cfg;
  logic [6:0]  boot_cfg;
  logic        pll_bypass;

  rst_seq_top dut (
    .clk(clk), .por_req(por_req), .full_req(full_req), .sys_req(sys_req),
    .core_req(core_req), .hold_cycles(hold_cycles), .strap_pins(strap_pins),
    .hib_flag(hib_flag), .resume_addr(resume_addr), .emu_rst(emu_rst),
    .iso_rst(iso_rst), .sys_rst(sys_rst), .core_rst(core_rst),
    .boot_start(boot_start), .resume_go(resume_go), .resume_pc(resume_pc),
    .strap_word(strap_word), .boot_dev(boot_dev), .boot_cfg(boot_cfg),
    .pll_mult(pll_mult), .ext_cfg(ext_cfg), .pll_bypass(pll_bypass)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_dom(input logic [3:0] exp, input string tag);
    logic [3:0] d;
    d = {emu_rst, iso_rst, sys_rst, core_rst};
    chk(d == exp, tag, {28'h0, d}, {28'h0, exp});
  endtask

  // m = {por, full, sys, core}; held for len rising edges.
  task automatic pulse(input logic [3:0] m, input int len);
    @(negedge clk);
    {por_req, full_req, sys_req, core_req} = m;
    repeat (len) @(negedge clk);
    {por_req, full_req, sys_req, core_req} = 4'b0;
  endtask

  task automatic wait_rel(output int n, output logic b, output logic r);
    n = 0; b = 1'b0; r = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n++;
      if (!core_rst) begin
        b = boot_start;
        r = resume_go;
        break;
      end
    end
  endtask

  function automatic logic [12:0] sw(input logic [2:0] top, input logic [6:0] cfg,
                                     input logic [2:0] dev);
    return {top, cfg, dev};
  endfunction

  int   n;
  logic b, r;
  logic [12:0] keep;

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk_dom(4'b1111, "R1 por domains");
    chk(strap_word == 13'h0, "R4 status zero during por", {19'h0, strap_word}, 32'h0);
    chk(boot_start == 1'b0, "R6 no boot during por", {31'h0, boot_start}, 32'h0);
  endtask

  task automatic t_por_release();
    @(negedge clk);
    por_req = 1'b0;
    wait_rel(n, b, r);
    chk(n == 4, "R3 por stretch", n, 4);
    chk(b == 1'b1 && r == 1'b0, "R6 boot after por", {30'h0, b, r}, 32'h2);
    chk(strap_word == sw(3'b110, 7'h5A, 3'b101), "R4 por latch", {19'h0, strap_word},
        {19'h0, sw(3'b110, 7'h5A, 3'b101)});
    chk(boot_dev == 3'b101 && boot_cfg == 7'h5A, "R9 fields", {22'h0, boot_cfg, boot_dev},
        {22'h0, 7'h5A, 3'b101});
    chk(pll_bypass == 0 && pll_mult == 3'b110 && ext_cfg == 0, "R10 non-bypass",
        {25'h0, pll_bypass, pll_mult, ext_cfg}, {25'h0, 1'b0, 3'b110, 3'b000});
    @(negedge clk);
    chk(boot_start == 1'b0, "R6 one-cycle pulse", {31'h0, boot_start}, 32'h0);
  endtask

  task automatic t_sys();
    keep = strap_word;
    strap_pins = sw(3'b011, 7'h11, 3'b001);
    hib_flag = 1'b1;
    pulse(4'b0010, 3);
    chk_dom(4'b0011, "R1 sys domains");
    wait_rel(n, b, r);
    chk(n == 4, "R3 sys stretch", n, 4);
    chk(b == 1'b1 && r == 1'b0, "R8 sys ignores hibernation", {30'h0, b, r}, 32'h2);
    chk(strap_word == keep, "R5 sys keeps status", {19'h0, strap_word}, {19'h0, keep});
    hib_flag = 1'b0;
  endtask

  task automatic t_core();
    keep = strap_word;
    pulse(4'b0001, 2);
    chk_dom(4'b0001, "R1 core domains");
    wait_rel(n, b, r);
    chk(b == 1'b0 && r == 1'b0, "R7 core no boot", {30'h0, b, r}, 32'h0);
    @(negedge clk);
    chk(boot_start == 1'b0 && resume_go == 1'b0, "R7 core no late pulse",
        {30'h0, boot_start, resume_go}, 32'h0);
    chk(strap_word == keep, "R5 core keeps status", {19'h0, strap_word}, {19'h0, keep});
  endtask

  task automatic t_full_serial();
    pulse(4'b0100, 2);
    chk_dom(4'b1111, "R1 full domains");
    wait_rel(n, b, r);
    chk(b == 1'b1, "R6 boot after full", {31'h0, b}, 32'h1);
    chk(strap_word == sw(3'b011, 7'h11, 3'b001), "R4 full latch", {19'h0, strap_word},
        {19'h0, sw(3'b011, 7'h11, 3'b001)});
    chk(pll_bypass && pll_mult == 0 && ext_cfg == 3'b011 && boot_cfg == 7'h11,
        "R10 i2c bypass", {25'h0, pll_bypass, pll_mult, ext_cfg}, {25'h0, 1'b1, 3'b000, 3'b011});
    strap_pins = sw(3'b101, 7'h22, 3'b010);
    hold_cycles = 16'd0;
    pulse(4'b0100, 2);
    wait_rel(n, b, r);
    chk(n == 1, "R3 zero stretch", n, 1);
    chk(pll_bypass && pll_mult == 0 && ext_cfg == 3'b101, "R10 spi bypass",
        {25'h0, pll_bypass, pll_mult, ext_cfg}, {25'h0, 1'b1, 3'b000, 3'b101});
  endtask

  task automatic t_simul();
    hold_cycles = 16'd2;
    pulse(4'b0011, 2);
    chk_dom(4'b0011, "R2 sys beats core");
    wait_rel(n, b, r);
    pulse(4'b0101, 2);
    chk_dom(4'b1111, "R2 full beats core");
    wait_rel(n, b, r);
    pulse(4'b0100, 2);
    pulse(4'b0001, 1);
    chk_dom(4'b1111, "R2 narrower keeps wide set");
    wait_rel(n, b, r);
    chk(n == 3, "R3 stretch reloaded", n, 3);
    chk(b == 1'b1, "R2 wide boot kept", {31'h0, b}, 32'h1);
  endtask

  task automatic t_hib();
    hib_flag = 1'b1;
    resume_addr = 32'h8000_1230;
    pulse(4'b0100, 2);
    wait_rel(n, b, r);
    chk(b == 1'b0 && r == 1'b1, "R8 resume not boot", {30'h0, b, r}, 32'h1);
    chk(resume_pc == 32'h8000_1230, "R8 resume address", resume_pc, 32'h8000_1230);
    hib_flag = 1'b0;
    @(negedge clk);
    chk(resume_go == 1'b0, "R8 resume one cycle", {31'h0, resume_go}, 32'h0);
  endtask

  task automatic t_sync();
    hold_cycles = 16'd3;
    strap_pins = sw(3'b001, 7'h7F, 3'b100);
    pulse(4'b0100, 2);
    @(negedge clk);
    @(negedge clk);
    strap_pins = sw(3'b111, 7'h01, 3'b110);
    wait_rel(n, b, r);
    chk(strap_word == sw(3'b001, 7'h7F, 3'b100), "R11 late change not captured",
        {19'h0, strap_word}, {19'h0, sw(3'b001, 7'h7F, 3'b100)});
    pulse(4'b0100, 2);
    wait_rel(n, b, r);
    chk(strap_word == sw(3'b111, 7'h01, 3'b110), "R11 settled change captured",
        {19'h0, strap_word}, {19'h0, sw(3'b111, 7'h01, 3'b110)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    por_req = 1'b1; full_req = 1'b0; sys_req = 1'b0; core_req = 1'b0;
    hold_cycles = 16'd3;
    strap_pins = sw(3'b110, 7'h5A, 3'b101);
    hib_flag = 1'b0;
    resume_addr = 32'h0;
    t_reset();
    t_por_release();
    t_sys();
    t_core();
    t_full_serial();
    t_simul();
    t_hib();
    t_sync();
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    finish_run();
  end
endmodule